// File: doc/BRIEF.md
# Software Interrupt Path Classifier

This block sits behind the instruction decoder of a processor core. It takes one decoded interrupt request, together with the current mode state and the attributes of the gate and target code segment that were already fetched. It then chooses exactly one way to service the request: a real-mode vector jump, a task switch, a same-level handler call, a call that changes privilege level, an exit from virtual mode, or a fault. It also reports the vector number, the fault class and a 16-bit error code in selector format, ready for the microcode that performs the stack pushes.

The block checks its conditions in a fixed order, and only the first condition that fails is reported. Requests arrive as a single-cycle strobe. The result appears one clock later with a one-cycle valid pulse, and it stays on the outputs until the next request. Events from outside the core use the same path with the external flag set. For these events the vector comes from the immediate byte, and the checks that apply only to software instructions are skipped.

Top module: `sic_classifier`

## Requirements
- R1: With `extEvent`=0, opcode 0xCC gives vector 3, opcode 0xCD gives vector `immByte`, and opcode 0xCE gives vector 4 when `ovFlag`=1. With `extEvent`=1 the vector is `immByte` whatever the opcode is.
- R2: Opcode 0xCE with `ovFlag`=0, or any other opcode with `extEvent`=0, gives a valid result with `pathSel`=0, `faultClass`=0, `vectorNum`=0 and `errCode`=0.
- R3: `outValid` is 1 in the cycle after a cycle in which `reqValid` is 1, and 0 otherwise. The other outputs keep their value until the next request.
- R4: When `peMode`=0, the real path (`pathSel` bit 0) is chosen if vector*4+3 <= `tableLimit`. Otherwise the result is a general-protection fault (`faultClass`=1, `pathSel` bit 5) with error code 0.
- R5: When `peMode`=1, `vmMode`=1 and `iopl`<3, a software request from opcode 0xCD raises a general-protection fault with error code 0, even when the immediate is 3. Opcode 0xCC and external events skip this check.
- R6: A general-protection fault with error code vector*8+2+`extEvent` is raised when vector*8+7 > `tableLimit` or when `gateKind` is 0. The gate kind encoding is: 0 invalid, 1 interrupt, 2 trap, 3 task.
- R7: For a software request, a gate DPL below `cpl` raises a general-protection fault with error code vector*8+2. External events skip this check.
- R8: A gate with `gatePresent`=0 raises a not-present fault (`faultClass`=2) with error code vector*8+2+`extEvent`.
- R9: A present, permitted task gate selects the task path (`pathSel` bit 1).
- R10: For an interrupt or trap gate, a null target selector (bits 15:2 all zero) raises a general-protection fault with error code `extEvent`.
- R11: A target segment DPL above `cpl` raises a general-protection fault with the selector code {`csSelector`[15:2], 0, `extEvent`}.
- R12: A nonconforming target with DPL below `cpl` selects the inter-privilege path (bit 3) when `vmMode`=0. When `vmMode`=1 it selects the from-virtual path (bit 4) if the target DPL is 0, and otherwise raises a general-protection fault with the selector code.
- R13: A conforming target, or a target DPL equal to `cpl`, selects the intra-privilege path (bit 2) when `vmMode`=0. When `vmMode`=1 it raises a general-protection fault with the selector code.
- R14: The checks are ranked as follows: virtual-mode privilege, table limit and type, software DPL, present, then the target segment checks. At most one `pathSel` bit is set. `faultClass` is nonzero exactly when bit 5 is set, and `errCode` is 0 on every non-fault path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle request strobe |
| opcode | input | 8 | Decoded opcode byte |
| immByte | input | 8 | Immediate byte, or vector of an external event |
| extEvent | input | 1 | 1 for an externally generated event |
| ovFlag | input | 1 | Overflow flag |
| peMode | input | 1 | Protection enabled |
| vmMode | input | 1 | Virtual-mode bit |
| iopl | input | 2 | I/O privilege level |
| cpl | input | 2 | Current privilege level |
| tableLimit | input | 16 | Interrupt table limit in bytes |
| gateKind | input | 2 | Gate kind: 0 invalid, 1 interrupt, 2 trap, 3 task |
| gateDpl | input | 2 | Gate descriptor privilege level |
| gatePresent | input | 1 | Gate present bit |
| csSelector | input | 16 | Target code segment selector held in the gate |
| csDpl | input | 2 | Target code segment DPL |
| csConforming | input | 1 | Target code segment is conforming |
| outValid | output | 1 | Result valid pulse |
| vectorNum | output | 8 | Resolved vector number |
| pathSel | output | 6 | One-hot path: 0 real, 1 task, 2 intra, 3 inter, 4 from-virtual, 5 fault |
| faultClass | output | 2 | 0 none, 1 general protection, 2 not present |
| errCode | output | 16 | Error code for the fault |

## Verification
The assertions assume that the mode and gate inputs stay steady during the request cycle, and that `reqValid` is a clean level sampled only at clock edges. They also assume that `cpl` is 3 whenever `vmMode` is set, so that the from-virtual rules make sense. The stimulus sets every input at the falling edge before it raises the strobe, changes nothing until after the capturing rising edge, and pairs virtual-mode cases with `cpl`=3. Each scenario starts from one known-good base configuration and then breaks one condition at a time, or two conditions where the ranking of the checks is under test.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam logic [7:0] OP_BREAK = 8'hCC;
  localparam logic [7:0] OP_SWINT = 8'hCD;
  localparam logic [7:0] OP_OVFTRAP = 8'hCE;

  localparam int PATH_N = 6;
  localparam int P_REAL = 0;
  localparam int P_TASK = 1;
  localparam int P_INTRA = 2;
  localparam int P_INTER = 3;
  localparam int P_FROMVM = 4;
  localparam int P_FAULT = 5;

  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_INTR = 2'd1,
    GATE_TRAP = 2'd2,
    GATE_TASK = 2'd3
  } gateKind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP = 2'd1,
    FLT_NP = 2'd2
  } faultKind_e;

  typedef enum logic [2:0] {
    CODE_ZERO = 3'd0,
    CODE_EXT_ONLY = 3'd1,
    CODE_VEC_EXT = 3'd2,
    CODE_VEC_SW = 3'd3,
    CODE_SEL_EXT = 3'd4
  } codeSrc_e;

  // Comparator and decode results handed from datapath to control
  typedef struct packed {
    logic noEvent;
    logic isSwN;
    logic realInLimit;
    logic protInLimit;
    logic selNull;
  } dpFlags_t;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic load;
    logic takeVec;
    logic [PATH_N-1:0] path;
    faultKind_e fault;
    codeSrc_e codeSrc;
  } ctrlStrobe_t;
endpackage

// File: rtl/sic_datapath.sv
module sic_datapath
  import sic_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LIM_W = 16,
  parameter int SEL_W = 16,
  parameter int ERR_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic [7:0] opcode,
  input  logic [VEC_W-1:0] immByte,
  input  logic extEvent,
  input  logic ovFlag,
  input  logic [LIM_W-1:0] tableLimit,
  input  logic [SEL_W-1:0] csSelector,
  input  ctrlStrobe_t strobe,
  output dpFlags_t flags,
  output logic outValid,
  output logic [VEC_W-1:0] vectorNum,
  output logic [PATH_N-1:0] pathSel,
  output logic [1:0] faultClass,
  output logic [ERR_W-1:0] errCode
);
  localparam int REAL_W = VEC_W + 2;
  localparam int PROT_W = VEC_W + 3;
  localparam int ADDR_W = (PROT_W > LIM_W) ? PROT_W : LIM_W;

  logic isBreak, isSwN, isOvf;
  logic [VEC_W-1:0] vecComb;
  logic [ADDR_W-1:0] realEnd, protEnd, limitExt;
  logic [ERR_W-1:0] vecCode, selCode, codeComb;

  // Opcode decode and vector selection
  always_comb begin
    isBreak = !extEvent && (opcode == OP_BREAK);
    isSwN = !extEvent && (opcode == OP_SWINT);
    isOvf = !extEvent && (opcode == OP_OVFTRAP) && ovFlag;
    if (extEvent) vecComb = immByte;
    else if (isBreak) vecComb = VEC_W'(3);
    else if (isSwN) vecComb = immByte;
    else if (isOvf) vecComb = VEC_W'(4);
    else vecComb = '0;
  end

  // Table end addresses for both table formats
  always_comb begin
    realEnd = ADDR_W'({vecComb, 2'b11});
    protEnd = ADDR_W'({vecComb, 3'b111});
    limitExt = ADDR_W'(tableLimit);
  end

  assign flags.noEvent = !extEvent && !(isBreak || isSwN || isOvf);
  assign flags.isSwN = isSwN;
  assign flags.realInLimit = (realEnd <= limitExt);
  assign flags.protInLimit = (protEnd <= limitExt);
  assign flags.selNull = (csSelector[SEL_W-1:2] == '0);

  // Error code formats
  always_comb begin
    vecCode = ERR_W'({vecComb, 3'b010});
    selCode = ERR_W'({csSelector[SEL_W-1:2], 1'b0, extEvent});
    unique case (strobe.codeSrc)
      CODE_EXT_ONLY: codeComb = ERR_W'(extEvent);
      CODE_VEC_EXT: codeComb = vecCode | ERR_W'(extEvent);
      CODE_VEC_SW: codeComb = vecCode;
      CODE_SEL_EXT: codeComb = selCode;
      default: codeComb = '0;
    endcase
  end

  // Output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      vectorNum <= '0;
      faultClass <= 2'd0;
      errCode <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        vectorNum <= strobe.takeVec ? vecComb : '0;
        faultClass <= strobe.fault;
        errCode <= codeComb;
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < PATH_N; gi++) begin : g_pathReg
      always_ff @(posedge clk) begin
        if (!rstN) pathSel[gi] <= 1'b0;
        else if (strobe.load) pathSel[gi] <= strobe.path[gi];
      end
    end
  endgenerate
endmodule

// File: rtl/sic_control.sv
module sic_control
  import sic_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic reqValid,
  input  logic extEvent,
  input  logic peMode,
  input  logic vmMode,
  input  logic [PL_W-1:0] iopl,
  input  logic [PL_W-1:0] cpl,
  input  logic [1:0] gateKind,
  input  logic [PL_W-1:0] gateDpl,
  input  logic gatePresent,
  input  logic [PL_W-1:0] csDpl,
  input  logic csConforming,
  input  dpFlags_t flags,
  output ctrlStrobe_t strobe
);
  localparam logic [PL_W-1:0] PL_MAX = '1;

  gateKind_e gk;
  assign gk = gateKind_e'(gateKind);

  always_comb begin
    strobe = '0;
    strobe.load = reqValid;
    strobe.takeVec = 1'b1;
    strobe.fault = FLT_NONE;
    strobe.codeSrc = CODE_ZERO;
    if (flags.noEvent) begin
      strobe.takeVec = 1'b0;
    end else if (!peMode) begin
      if (flags.realInLimit) begin
        strobe.path[P_REAL] = 1'b1;
      end else begin
        strobe.path[P_FAULT] = 1'b1;
        strobe.fault = FLT_GP;
      end
    end else if (vmMode && (iopl != PL_MAX) && flags.isSwN) begin
      strobe.path[P_FAULT] = 1'b1;
      strobe.fault = FLT_GP;
    end else if (!flags.protInLimit || (gk == GATE_NONE)) begin
      strobe.path[P_FAULT] = 1'b1;
      strobe.fault = FLT_GP;
      strobe.codeSrc = CODE_VEC_EXT;
    end else if (!extEvent && (gateDpl < cpl)) begin
      strobe.path[P_FAULT] = 1'b1;
      strobe.fault = FLT_GP;
      strobe.codeSrc = CODE_VEC_SW;
    end else if (!gatePresent) begin
      strobe.path[P_FAULT] = 1'b1;
      strobe.fault = FLT_NP;
      strobe.codeSrc = CODE_VEC_EXT;
    end else if (gk == GATE_TASK) begin
      strobe.path[P_TASK] = 1'b1;
    end else if (flags.selNull) begin
      strobe.path[P_FAULT] = 1'b1;
      strobe.fault = FLT_GP;
      strobe.codeSrc = CODE_EXT_ONLY;
    end else if (csDpl > cpl) begin
      strobe.path[P_FAULT] = 1'b1;
      strobe.fault = FLT_GP;
      strobe.codeSrc = CODE_SEL_EXT;
    end else if (!csConforming && (csDpl < cpl)) begin
      if (!vmMode) begin
        strobe.path[P_INTER] = 1'b1;
      end else if (csDpl == '0) begin
        strobe.path[P_FROMVM] = 1'b1;
      end else begin
        strobe.path[P_FAULT] = 1'b1;
        strobe.fault = FLT_GP;
        strobe.codeSrc = CODE_SEL_EXT;
      end
    end else if (vmMode) begin
      strobe.path[P_FAULT] = 1'b1;
      strobe.fault = FLT_GP;
      strobe.codeSrc = CODE_SEL_EXT;
    end else begin
      strobe.path[P_INTRA] = 1'b1;
    end
  end
endmodule

// File: rtl/sic_classifier.sv
module sic_classifier
  import sic_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LIM_W = 16,
  parameter int SEL_W = 16,
  parameter int ERR_W = 16,
  parameter int PL_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic [7:0] opcode,
  input  logic [VEC_W-1:0] immByte,
  input  logic extEvent,
  input  logic ovFlag,
  input  logic peMode,
  input  logic vmMode,
  input  logic [PL_W-1:0] iopl,
  input  logic [PL_W-1:0] cpl,
  input  logic [LIM_W-1:0] tableLimit,
  input  logic [1:0] gateKind,
  input  logic [PL_W-1:0] gateDpl,
  input  logic gatePresent,
  input  logic [SEL_W-1:0] csSelector,
  input  logic [PL_W-1:0] csDpl,
  input  logic csConforming,
  output logic outValid,
  output logic [VEC_W-1:0] vectorNum,
  output logic [PATH_N-1:0] pathSel,
  output logic [1:0] faultClass,
  output logic [ERR_W-1:0] errCode
);
  dpFlags_t flags;
  ctrlStrobe_t strobe;

  sic_control #(.PL_W(PL_W)) u_ctrl (
    .reqValid(reqValid), .extEvent(extEvent), .peMode(peMode), .vmMode(vmMode),
    .iopl(iopl), .cpl(cpl), .gateKind(gateKind), .gateDpl(gateDpl),
    .gatePresent(gatePresent), .csDpl(csDpl), .csConforming(csConforming),
    .flags(flags), .strobe(strobe)
  );

  sic_datapath #(.VEC_W(VEC_W), .LIM_W(LIM_W), .SEL_W(SEL_W), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .opcode(opcode), .immByte(immByte),
    .extEvent(extEvent), .ovFlag(ovFlag), .tableLimit(tableLimit),
    .csSelector(csSelector), .strobe(strobe), .flags(flags),
    .outValid(outValid), .vectorNum(vectorNum), .pathSel(pathSel),
    .faultClass(faultClass), .errCode(errCode)
  );
endmodule

// File: rtl/sic_classifier_chk.sv
module sic_classifier_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic [7:0] opcode,
  input logic extEvent,
  input logic peMode,
  input logic vmMode,
  input logic [1:0] iopl,
  input logic outValid,
  input logic [7:0] vectorNum,
  input logic [5:0] pathSel,
  input logic [1:0] faultClass,
  input logic [15:0] errCode
);
  p_valid_follows_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  p_valid_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(vectorNum) && $stable(errCode) && $stable(pathSel)));
  p_path_onehot_r14: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pathSel));
  p_fault_class_r14: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (pathSel[5] == (faultClass != 2'd0)));
  p_clean_code_r14: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !pathSel[5]) |-> (errCode == 16'd0));
  p_vm_iopl_gp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && peMode && vmMode && (iopl != 2'd3) && !extEvent && (opcode == 8'hCD))
      |=> (pathSel[5] && (faultClass == 2'd1) && (errCode == 16'd0)));
  p_np_table_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (faultClass == 2'd2)) |-> (errCode[1] && (errCode[10:3] == vectorNum)));
endmodule

bind sic_classifier sic_classifier_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode),
  .extEvent(extEvent), .peMode(peMode), .vmMode(vmMode), .iopl(iopl),
  .outValid(outValid), .vectorNum(vectorNum), .pathSel(pathSel),
  .faultClass(faultClass), .errCode(errCode)
);

// File: tb/sic_classifier_tb.sv
`timescale 1ns/1ps
module sic_classifier_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] immByte = 8'h00;
  logic extEvent = 1'b0;
  logic ovFlag = 1'b0;
  logic peMode = 1'b0;
  logic vmMode = 1'b0;
  logic [1:0] iopl = 2'd0;
  logic [1:0] cpl = 2'd0;
  logic [15:0] tableLimit = 16'h0;
  logic [1:0] gateKind = 2'd0;
  logic [1:0] gateDpl = 2'd0;
  logic gatePresent = 1'b0;
  logic [15:0] csSelector = 16'h0;
  logic [1:0] csDpl = 2'd0;
  logic csConforming = 1'b0;
  logic outValid;
  logic [7:0] vectorNum;
  logic [5:0] pathSel;
  logic [1:0] faultClass;
  logic [15:0] errCode;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  localparam logic [5:0] PR = 6'b000001, PT = 6'b000010, PA = 6'b000100;
  localparam logic [5:0] PI = 6'b001000, PV = 6'b010000, PF = 6'b100000;

  always #2 clk = ~clk;

  sic_classifier u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode), .immByte(immByte),
    .extEvent(extEvent), .ovFlag(ovFlag), .peMode(peMode), .vmMode(vmMode),
    .iopl(iopl), .cpl(cpl), .tableLimit(tableLimit), .gateKind(gateKind),
    .gateDpl(gateDpl), .gatePresent(gatePresent), .csSelector(csSelector),
    .csDpl(csDpl), .csConforming(csConforming), .outValid(outValid),
    .vectorNum(vectorNum), .pathSel(pathSel), .faultClass(faultClass), .errCode(errCode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Known-good protected-mode setup: interrupt gate leading to the inter-privilege path
  task automatic setBase();
    opcode = 8'hCD; immByte = 8'h21; extEvent = 1'b0; ovFlag = 1'b0;
    peMode = 1'b1; vmMode = 1'b0; iopl = 2'd0; cpl = 2'd3;
    tableLimit = 16'h07FF; gateKind = 2'd1; gateDpl = 2'd3; gatePresent = 1'b1;
    csSelector = 16'h0010; csDpl = 2'd0; csConforming = 1'b0;
  endtask

  // Issue one request and compare the registered result
  task automatic doReq(input string tag, input logic [7:0] eVec, input logic [5:0] ePath,
                       input logic [1:0] eFlt, input logic [15:0] eErr);
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " valid"}, 32'(outValid), 32'd1);
    check({tag, " result"}, {vectorNum, pathSel, faultClass, errCode},
          {eVec, ePath, eFlt, eErr});
  endtask

  task automatic tReset();
    check("R3 reset valid", 32'(outValid), 32'd0);
    check("R3 reset path", 32'(pathSel), 32'd0);
  endtask

  task automatic tDecode();
    setBase(); doReq("R1 swint imm", 8'h21, PI, 2'd0, 16'h0);
    setBase(); opcode = 8'hCC; doReq("R1 break vec3", 8'h03, PI, 2'd0, 16'h0);
    setBase(); opcode = 8'hCE; ovFlag = 1'b1; doReq("R1 ovf vec4", 8'h04, PI, 2'd0, 16'h0);
    setBase(); opcode = 8'h00; extEvent = 1'b1; immByte = 8'h40;
    doReq("R1 ext vec", 8'h40, PI, 2'd0, 16'h0);
  endtask

  task automatic tNoEvent();
    setBase(); opcode = 8'hCE; ovFlag = 1'b0; doReq("R2 ovf clear", 8'h00, 6'b0, 2'd0, 16'h0);
    setBase(); opcode = 8'h90; doReq("R2 other opcode", 8'h00, 6'b0, 2'd0, 16'h0);
  endtask

  task automatic tTiming();
    setBase(); immByte = 8'h55; doReq("R3 pulse", 8'h55, PI, 2'd0, 16'h0);
    immByte = 8'h66;
    @(negedge clk);
    check("R3 valid drops", 32'(outValid), 32'd0);
    check("R3 held", {vectorNum, pathSel}, {8'h55, PI});
  endtask

  task automatic tReal();
    setBase(); peMode = 1'b0; immByte = 8'hFF; tableLimit = 16'h03FF;
    doReq("R4 real in limit", 8'hFF, PR, 2'd0, 16'h0);
    tableLimit = 16'h03FE; doReq("R4 real over", 8'hFF, PF, 2'd1, 16'h0);
  endtask

  task automatic tVirtual();
    setBase(); vmMode = 1'b1; immByte = 8'h03;
    doReq("R5 swint imm3 gp", 8'h03, PF, 2'd1, 16'h0);
    setBase(); vmMode = 1'b1; opcode = 8'hCC;
    doReq("R5 break exempt", 8'h03, PV, 2'd0, 16'h0);
    setBase(); vmMode = 1'b1; extEvent = 1'b1; immByte = 8'h20;
    doReq("R5 ext exempt", 8'h20, PV, 2'd0, 16'h0);
    setBase(); vmMode = 1'b1; iopl = 2'd3;
    doReq("R5 iopl3 ok", 8'h21, PV, 2'd0, 16'h0);
  endtask

  task automatic tLimit();
    setBase(); tableLimit = 16'h010E; doReq("R6 over limit", 8'h21, PF, 2'd1, 16'h010A);
    extEvent = 1'b1; doReq("R6 over limit ext", 8'h21, PF, 2'd1, 16'h010B);
    setBase(); tableLimit = 16'h010F; doReq("R6 exact limit", 8'h21, PI, 2'd0, 16'h0);
    setBase(); gateKind = 2'd0; doReq("R6 bad type", 8'h21, PF, 2'd1, 16'h010A);
  endtask

  task automatic tGateDpl();
    setBase(); gateDpl = 2'd0; doReq("R7 sw dpl", 8'h21, PF, 2'd1, 16'h010A);
    extEvent = 1'b1; doReq("R7 ext skips dpl", 8'h21, PI, 2'd0, 16'h0);
  endtask

  task automatic tPresent();
    setBase(); gatePresent = 1'b0; doReq("R8 np", 8'h21, PF, 2'd2, 16'h010A);
    extEvent = 1'b1; doReq("R8 np ext", 8'h21, PF, 2'd2, 16'h010B);
  endtask

  task automatic tTask();
    setBase(); gateKind = 2'd3; csSelector = 16'h0; doReq("R9 task", 8'h21, PT, 2'd0, 16'h0);
  endtask

  task automatic tSegment();
    setBase(); csSelector = 16'h0003; doReq("R10 null sel", 8'h21, PF, 2'd1, 16'h0000);
    extEvent = 1'b1; doReq("R10 null sel ext", 8'h21, PF, 2'd1, 16'h0001);
    setBase(); cpl = 2'd0; gateDpl = 2'd0; csDpl = 2'd2;
    doReq("R11 dpl above", 8'h21, PF, 2'd1, 16'h0010);
    csSelector = 16'h001F; extEvent = 1'b1;
    doReq("R11 sel code ext", 8'h21, PF, 2'd1, 16'h001D);
    setBase(); vmMode = 1'b1; iopl = 2'd3; csDpl = 2'd1;
    doReq("R12 vm dpl1", 8'h21, PF, 2'd1, 16'h0010);
    setBase(); cpl = 2'd2; gateDpl = 2'd2; csDpl = 2'd2;
    doReq("R13 equal intra", 8'h21, PA, 2'd0, 16'h0);
    setBase(); csConforming = 1'b1; doReq("R13 conforming", 8'h21, PA, 2'd0, 16'h0);
    setBase(); vmMode = 1'b1; iopl = 2'd3; csDpl = 2'd3;
    doReq("R13 vm equal gp", 8'h21, PF, 2'd1, 16'h0010);
  endtask

  task automatic tPriority();
    setBase(); vmMode = 1'b1; tableLimit = 16'h0; doReq("R14 vm first", 8'h21, PF, 2'd1, 16'h0);
    setBase(); gateDpl = 2'd0; gatePresent = 1'b0;
    doReq("R14 dpl before np", 8'h21, PF, 2'd1, 16'h010A);
    setBase(); gateKind = 2'd0; gatePresent = 1'b0;
    doReq("R14 type before np", 8'h21, PF, 2'd1, 16'h010A);
    setBase(); gatePresent = 1'b0; csSelector = 16'h0;
    doReq("R14 np before sel", 8'h21, PF, 2'd2, 16'h010A);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          nChecks++; nFails++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
          $finish;
        end
      end
    join_none
    repeat (3) @(posedge clk);
    @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tDecode();
    tNoEvent();
    tTiming();
    tReal();
    tVirtual();
    tLimit();
    tGateDpl();
    tPresent();
    tTask();
    tSegment();
    tPriority();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule